// File: doc/BRIEF.md
# Interleaving Write Data Acceptor

This block is the target-side front end of a write path. Write addresses arrive with a transaction ID and wait in an in-order pending queue. Write data beats carry their own ID and a last-beat marker. A beat may belong to any of the oldest `DEPTH` pending addresses, so beats of transactions with different IDs can be interleaved. `DEPTH` is a static parameter whose default of one allows no interleaving. The ID of each beat is matched against that eligible window. The beat is then routed to the transaction's slot, whose beat counter gives the word address of the beat.

The data channel is never stalled: `w_ready` stays high, so the block can never hold data back to force a different order. A beat that fits no eligible transaction is dropped and raises a sticky error. A transaction that starts before an older eligible one raises a separate sticky ordering error. A last beat retires its transaction, emits a one-cycle completion pulse and lets the next pending address into the window. The backing memory and the write response path sit outside this block.

Top module: `wdi_acceptor`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `bt_valid`, `done_valid`, `err_nomatch` and `err_order` are 0, `aw_ready` is 1, and the pending queue is empty.
- R2: `aw_ready` is 0 exactly when `QDEPTH` addresses are pending. An address offered while `aw_ready` is 0 is not taken.
- R3: `w_ready` is 1 in every cycle, whatever data is offered.
- R4: A beat can match only the oldest `min(DEPTH, pending)` entries, counted from the oldest. A beat whose ID belongs only to a younger entry is treated as unmatched.
- R5: A beat accepted at a clock edge that matches entry E shows up on `bt_*` in the next cycle. `bt_addr` is E's address plus the number of beats E has already taken, `bt_data` is the beat's data and `bt_id` is its ID.
- R6: When two eligible entries share the beat's ID, the beat goes to the older entry.
- R7: A matched beat with `w_last` set retires its entry. In the next cycle it gives a one-cycle `done_valid` with `done_id` and `done_beats` (the total beat count), and the younger entries move one place closer to the head.
- R8: `err_order` becomes 1 and stays 1 until reset when a matched beat is the first beat of its entry while an older entry in the window has no beat yet. That beat is still routed.
- R9: An unmatched beat produces no `bt_valid` and changes no entry. It sets `err_nomatch`, which stays 1 until reset.
- R10: An address accepted at a clock edge becomes eligible for data from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aw_valid | input | 1 | Address offered |
| aw_ready | output | 1 | Pending queue has room |
| aw_id | input | ID_W | Transaction ID of the address |
| aw_addr | input | ADDR_W | Start word address |
| w_valid | input | 1 | Data beat offered |
| w_ready | output | 1 | Data always accepted |
| w_id | input | ID_W | ID of the data beat |
| w_data | input | DATA_W | Beat payload |
| w_last | input | 1 | Final beat of its transaction |
| bt_valid | output | 1 | Routed beat valid |
| bt_addr | output | ADDR_W | Word address of the routed beat |
| bt_data | output | DATA_W | Payload of the routed beat |
| bt_id | output | ID_W | ID of the routed beat |
| done_valid | output | 1 | Transaction completion pulse |
| done_id | output | ID_W | ID of the finished transaction |
| done_beats | output | BEAT_W | Beats in the finished transaction |
| err_nomatch | output | 1 | Sticky: beat fit no eligible entry |
| err_order | output | 1 | Sticky: first beats out of address order |

## Verification
A beat counter that fails to advance or to clear shows up on `bt_addr` one cycle after the beat. A wrong count shows in `done_beats` at the end of that transaction. If the queue compacts wrongly on a retire, the next beat shows it: the beat is routed to a stale address or flagged as unmatched. A bad window bound shows as a missing or extra `bt_valid`, and a broken start check shows as a wrong `err_order` level, in the cycle after the offending beat. A reference model of the queue in the bench predicts every output each cycle, so any of these faults is reported within one cycle of the beat that exposes it.

// File: rtl/wdi_pkg.sv
package wdi_pkg;
  function automatic int min_int(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wdi_addr_queue.sv
module wdi_addr_queue #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 8,
  parameter int Q      = 4,
  parameter int IDX_W  = 2,
  parameter int CTW    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [ID_W-1:0]   push_id,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              adv,
  input  logic [IDX_W-1:0]  adv_idx,
  input  logic              adv_last,
  output logic [ID_W-1:0]   q_id   [Q],
  output logic [ADDR_W-1:0] q_addr [Q],
  output logic [BEAT_W-1:0] q_cnt  [Q],
  output logic [CTW-1:0]    q_count
);
  logic [ID_W-1:0]   n_id   [Q];
  logic [ADDR_W-1:0] n_addr [Q];
  logic [BEAT_W-1:0] n_cnt  [Q];
  logic [CTW-1:0]    n_count;

  always_comb begin
    for (int i = 0; i < Q; i++) begin
      n_id[i]   = q_id[i];
      n_addr[i] = q_addr[i];
      n_cnt[i]  = q_cnt[i];
    end
    n_count = q_count;
    if (adv) begin
      if (adv_last) begin
        for (int i = 0; i < Q - 1; i++) begin
          if (i >= int'(adv_idx)) begin
            n_id[i]   = q_id[i+1];
            n_addr[i] = q_addr[i+1];
            n_cnt[i]  = q_cnt[i+1];
          end
        end
        n_count = q_count - CTW'(1);
      end else begin
        n_cnt[adv_idx] = q_cnt[adv_idx] + BEAT_W'(1);
      end
    end
    if (push) begin
      for (int i = 0; i < Q; i++) begin
        if (i == int'(n_count)) begin
          n_id[i]   = push_id;
          n_addr[i] = push_addr;
          n_cnt[i]  = '0;
        end
      end
      n_count = n_count + CTW'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < Q; i++) begin
      q_id[i]   <= n_id[i];
      q_addr[i] <= n_addr[i];
      q_cnt[i]  <= n_cnt[i];
    end
    if (rst) q_count <= '0;
    else     q_count <= n_count;
  end

  p_push_room_r2: assert property (@(posedge clk) disable iff (rst)
    push |-> (int'(q_count) < Q));
  p_adv_pending_r9: assert property (@(posedge clk) disable iff (rst)
    adv |-> (int'(adv_idx) < int'(q_count)));
  p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
    (adv && adv_last && !push) |=> (q_count == $past(q_count) - CTW'(1)));
endmodule

// File: rtl/wdi_match.sv
module wdi_match #(
  parameter int ID_W   = 4,
  parameter int BEAT_W = 8,
  parameter int Q      = 4,
  parameter int WIN    = 1,
  parameter int IDX_W  = 2,
  parameter int CTW    = 3
) (
  input  logic [ID_W-1:0]   q_id [Q],
  input  logic [BEAT_W-1:0] q_cnt [Q],
  input  logic [CTW-1:0]    q_count,
  input  logic [ID_W-1:0]   w_id,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic              ooo
);
  logic older_idle;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = WIN - 1; i >= 0; i--) begin
      if (i < int'(q_count) && q_id[i] == w_id) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
    older_idle = 1'b0;
    for (int j = 0; j < WIN; j++) begin
      if (j < int'(idx) && q_cnt[j] == '0) older_idle = 1'b1;
    end
    ooo = hit && (q_cnt[idx] == '0) && older_idle;
  end
endmodule

// File: rtl/wdi_acceptor.sv
module wdi_acceptor
  import wdi_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BEAT_W = 8,
  parameter int DEPTH  = 1,
  parameter int QDEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              aw_valid,
  output logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [ID_W-1:0]   w_id,
  input  logic [DATA_W-1:0] w_data,
  input  logic              w_last,
  output logic              bt_valid,
  output logic [ADDR_W-1:0] bt_addr,
  output logic [DATA_W-1:0] bt_data,
  output logic [ID_W-1:0]   bt_id,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id,
  output logic [BEAT_W-1:0] done_beats,
  output logic              err_nomatch,
  output logic              err_order
);
  localparam int WIN   = min_int(DEPTH, QDEPTH);
  localparam int IDX_W = idx_width(QDEPTH);
  localparam int CTW   = $clog2(QDEPTH + 1);

  logic [ID_W-1:0]   q_id   [QDEPTH];
  logic [ADDR_W-1:0] q_addr [QDEPTH];
  logic [BEAT_W-1:0] q_cnt  [QDEPTH];
  logic [CTW-1:0]    q_count;
  logic              hit, ooo, take_aw, take_w;
  logic [IDX_W-1:0]  idx;

  assign aw_ready = (int'(q_count) < QDEPTH);
  assign w_ready  = 1'b1;
  assign take_aw  = aw_valid && aw_ready;
  assign take_w   = w_valid && hit;

  wdi_addr_queue #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .BEAT_W(BEAT_W),
    .Q(QDEPTH), .IDX_W(IDX_W), .CTW(CTW)
  ) i_queue (
    .clk(clk), .rst(rst),
    .push(take_aw), .push_id(aw_id), .push_addr(aw_addr),
    .adv(take_w), .adv_idx(idx), .adv_last(w_last),
    .q_id(q_id), .q_addr(q_addr), .q_cnt(q_cnt), .q_count(q_count)
  );

  wdi_match #(
    .ID_W(ID_W), .BEAT_W(BEAT_W), .Q(QDEPTH),
    .WIN(WIN), .IDX_W(IDX_W), .CTW(CTW)
  ) i_match (
    .q_id(q_id), .q_cnt(q_cnt), .q_count(q_count), .w_id(w_id),
    .hit(hit), .idx(idx), .ooo(ooo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bt_valid    <= 1'b0;
      bt_addr     <= '0;
      bt_data     <= '0;
      bt_id       <= '0;
      done_valid  <= 1'b0;
      done_id     <= '0;
      done_beats  <= '0;
      err_nomatch <= 1'b0;
      err_order   <= 1'b0;
    end else begin
      bt_valid   <= take_w;
      done_valid <= take_w && w_last;
      if (take_w) begin
        bt_addr    <= q_addr[idx] + ADDR_W'(q_cnt[idx]);
        bt_data    <= w_data;
        bt_id      <= w_id;
        done_id    <= w_id;
        done_beats <= q_cnt[idx] + BEAT_W'(1);
      end
      err_nomatch <= err_nomatch | (w_valid && !hit);
      err_order   <= err_order | (w_valid && ooo);
    end
  end

  p_beat_source_r5: assert property (@(posedge clk) disable iff (rst)
    bt_valid |-> $past(w_valid));
  p_done_source_r7: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> ($past(w_valid && w_last) && bt_valid));
  p_hit_window_r4: assert property (@(posedge clk) disable iff (rst)
    hit |-> (int'(idx) < WIN && q_id[idx] == w_id));
  p_nomatch_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_nomatch |=> err_nomatch);
  p_order_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_order |=> err_order);
  p_aw_ready_r2: assert property (@(posedge clk) disable iff (rst)
    (!aw_ready && !(w_valid && hit && w_last)) |=> !aw_ready);
endmodule

// File: tb/test_wdi_acceptor.sv
module test_wdi_acceptor;
  localparam int Q = 4;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rst;
  logic aw_valid, w_valid, w_last;
  logic [3:0] aw_id, w_id;
  logic [15:0] aw_addr;
  logic [31:0] w_data;
  logic aw_ready, w_ready, bt_valid, done_valid, err_nomatch, err_order;
  logic [15:0] bt_addr;
  logic [31:0] bt_data;
  logic [3:0] bt_id, done_id;
  logic [7:0] done_beats;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0]  m_id [Q];
  logic [15:0] m_addr [Q];
  logic [7:0]  m_cnt [Q];
  int m_n;
  logic e_nm, e_ord;

  always #4 clk = ~clk;

  wdi_acceptor #(.ID_W(4), .ADDR_W(16), .DATA_W(32), .BEAT_W(8),
                 .DEPTH(W), .QDEPTH(Q)) i_wdi_acceptor (
    .clk(clk), .rst(rst),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr),
    .w_valid(w_valid), .w_ready(w_ready), .w_id(w_id), .w_data(w_data), .w_last(w_last),
    .bt_valid(bt_valid), .bt_addr(bt_addr), .bt_data(bt_data), .bt_id(bt_id),
    .done_valid(done_valid), .done_id(done_id), .done_beats(done_beats),
    .err_nomatch(err_nomatch), .err_order(err_order)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int win_size();
    return (m_n < W) ? m_n : W;
  endfunction

  task automatic do_reset();
    rst = 1'b1; aw_valid = 0; w_valid = 0; w_last = 0;
    aw_id = 0; aw_addr = 0; w_id = 0; w_data = 0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 bt_valid in reset", bt_valid, 0);
    chk("R1 err_nomatch in reset", err_nomatch, 0);
    rst = 1'b0;
    m_n = 0; e_nm = 0; e_ord = 0;
    chk("R1 aw_ready", aw_ready, 1);
    chk("R1 done_valid", done_valid, 0);
    chk("R1 err_order", err_order, 0);
  endtask

  task automatic cyc(input logic av, input logic [3:0] aid, input logic [15:0] aad,
                     input logic wv, input logic [3:0] wid, input logic [31:0] wd,
                     input logic wl);
    int h;
    logic x_bt, x_done, idle;
    logic [15:0] x_addr;
    logic [7:0] x_beats;
    aw_valid = av; aw_id = aid; aw_addr = aad;
    w_valid = wv; w_id = wid; w_data = wd; w_last = wl;
    chk("R2 aw_ready level", aw_ready, (m_n < Q));
    chk("R3 w_ready high", w_ready, 1);
    h = -1;
    for (int i = win_size() - 1; i >= 0; i--) if (m_id[i] == wid) h = i;
    x_bt = wv && (h >= 0);
    x_done = x_bt && wl;
    x_addr = 0; x_beats = 0;
    if (wv && h < 0) e_nm = 1;
    if (x_bt) begin
      x_addr = m_addr[h] + 16'(m_cnt[h]);
      x_beats = m_cnt[h] + 8'd1;
      idle = 0;
      for (int j = 0; j < h; j++) if (m_cnt[j] == 0) idle = 1;
      if (m_cnt[h] == 0 && idle) e_ord = 1;
      if (wl) begin
        for (int j = h; j < Q - 1; j++) begin
          m_id[j] = m_id[j+1]; m_addr[j] = m_addr[j+1]; m_cnt[j] = m_cnt[j+1];
        end
        m_n--;
      end else m_cnt[h]++;
    end
    if (av && m_n < Q + (x_done ? 1 : 0) && (m_n < Q || !x_done)) begin
      // address capacity is judged before the retire (R2)
    end
    if (av && (m_n + (x_done ? 1 : 0)) < Q) begin
      m_id[m_n] = aid; m_addr[m_n] = aad; m_cnt[m_n] = 0; m_n++;
    end
    @(posedge clk);
    #2;
    chk("R5 bt_valid", bt_valid, x_bt);
    if (x_bt) begin
      chk("R5 bt_addr", bt_addr, x_addr);
      chk("R5 bt_data", bt_data, wd);
      chk("R6 bt_id", bt_id, wid);
    end
    chk("R7 done_valid", done_valid, x_done);
    if (x_done) begin
      chk("R7 done_id", done_id, wid);
      chk("R7 done_beats", done_beats, x_beats);
    end
    chk("R9 err_nomatch", err_nomatch, e_nm);
    chk("R8 err_order", err_order, e_ord);
    aw_valid = 0; w_valid = 0; w_last = 0;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int sd;
    logic [3:0] rid;
    sd = $urandom(32'd7301);
    do_reset();
    // R10: address and same-cycle beat for it -> beat unmatched
    cyc(1, 4'd1, 16'd100, 1, 4'd1, 32'hA0, 0);
    cyc(0, 0, 0, 1, 4'd1, 32'hA1, 0);
    do_reset();
    cyc(1, 4'd1, 16'd100, 0, 0, 0, 0);
    cyc(1, 4'd2, 16'd200, 0, 0, 0, 0);
    cyc(1, 4'd3, 16'd300, 0, 0, 0, 0);
    cyc(1, 4'd1, 16'd400, 0, 0, 0, 0);
    cyc(1, 4'd9, 16'd900, 0, 0, 0, 0);            // R2 full: rejected
    cyc(0, 0, 0, 1, 4'd1, 32'h11, 0);              // R6 older id1 wins
    cyc(0, 0, 0, 1, 4'd2, 32'h21, 0);              // R4 interleave in window
    cyc(0, 0, 0, 1, 4'd1, 32'h12, 1);              // R7 retire id1
    cyc(0, 0, 0, 1, 4'd3, 32'h31, 0);              // window moved
    cyc(0, 0, 0, 1, 4'd2, 32'h22, 1);
    cyc(0, 0, 0, 1, 4'd3, 32'h32, 1);
    cyc(0, 0, 0, 1, 4'd1, 32'h41, 1);              // younger id1 at 400
    cyc(0, 0, 0, 1, 4'd1, 32'h42, 1);              // R9 queue empty
    do_reset();
    cyc(1, 4'd1, 16'd10, 0, 0, 0, 0);
    cyc(1, 4'd2, 16'd20, 0, 0, 0, 0);
    cyc(1, 4'd3, 16'd30, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 4'd3, 32'h5, 0);               // R4 beyond window
    do_reset();
    cyc(1, 4'd4, 16'd40, 0, 0, 0, 0);
    cyc(1, 4'd5, 16'd50, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 4'd5, 32'h55, 0);              // R8 id5 before id4
    cyc(0, 0, 0, 1, 4'd4, 32'h44, 1);
    do_reset();
    for (int k = 0; k < 600; k++) begin
      if (win_size() > 0 && ($urandom % 5) != 0) rid = m_id[$urandom % win_size()];
      else rid = 4'($urandom % 4);
      cyc(($urandom % 2) == 0, 4'($urandom % 4), 16'($urandom),
          ($urandom % 3) != 0, rid, $urandom, ($urandom % 3) == 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule